// File: doc/BRIEF.md
# Supply Threshold Edge Event Unit

This block is the digital half of a programmable supply-voltage monitor. Software picks one of eight threshold codes and turns monitoring on through a small register interface. The block passes the code and an enable to the analog comparator. Seven codes select internal levels between 2.0 V and 2.9 V. The eighth code selects an external analog input, which the comparator checks against the internal reference.

The comparator result arrives as an asynchronous digital level. The block synchronizes it and shows it as a status bit. Upward and downward crossings each set their own sticky pending bit. Each pending bit can drive a level interrupt, a one-cycle event pulse, or both. Software clears a pending bit by writing 1 to its position.

A power-mode input tells the block which low-power state the chip is in. Detection keeps running in both stop modes. In standby, detection is forced off.

Top module: `supply_edge_unit`

## Requirements
- R1: After a synchronous reset, every register reads 0 and the outputs irq, evt and det_on are low.
- R2: The control register at address 0 holds the enable in bit 0 and the threshold code in bits 3:1. It reads back as written, and lvl_sel shows the code. Codes 0 to 6 are internal levels and code 7 selects the external input.
- R3: The mode register at address 1 has four bits: bit 0 arms upward crossings, bit 1 arms downward crossings, bit 2 routes pending bits to the interrupt, and bit 3 routes crossings to the event output. Each write replaces all four bits, so any bit not requested reads back 0.
- R4: Status at address 2 has three bits. Bit 0 is the synchronized comparator level (1 = supply above the threshold) while detection is active, and 0 otherwise. Bit 1 is the upward-crossing pending bit. Bit 2 is the downward-crossing pending bit. Address 3 reads 0. Read data appears one clock after the address.
- R5: An upward crossing sets bit 1 only when mode bit 0 is set. A downward crossing sets bit 2 only when mode bit 1 is set. A crossing of a type that is not armed leaves the pending bits unchanged.
- R6: Writing status with bit 1 or bit 2 at 1 clears only that pending bit. Writing 0 to a position leaves that bit as it was.
- R7: If a crossing sets a pending bit in the same cycle that a write clears it, the bit ends up set.
- R8: With mode bit 3 set, each recorded crossing gives exactly one one-cycle pulse on evt. With mode bit 3 clear, evt stays low.
- R9: irq is high while mode bit 2 is set and at least one pending bit is set. It is low otherwise.
- R10: lp_mode encodes 0 as run, 1 as stop 0, 2 as stop 1 and 3 as standby. Crossings are detected in run and in both stop modes. In standby, status bit 0 reads 0 and no crossing is recorded. A return from standby while the comparator is high records no crossing.
- R11: det_on is high exactly when the enable bit is set and lp_mode is not standby, one clock after either input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| cmp_in | input | 1 | Raw comparator result, 1 = supply above threshold |
| lp_mode | input | 2 | Current low-power state |
| lvl_sel | output | 3 | Threshold code to the analog side |
| det_on | output | 1 | Comparator enable to the analog side |
| irq | output | 1 | Level interrupt |
| evt | output | 1 | One-cycle event pulse |

## Verification
The hardest case to reach from the ports is a software clear that lands in the same clock as a new crossing on the same pending bit. The comparator input travels through the synchronizer and the edge register before the pending bit is set. To hit that clock, the bench counts those stages after changing cmp_in and raises the clear write so it is sampled on that exact edge. The second hard case is a return from standby with the comparator already high. The bench drives cmp_in high while in standby and then checks that no upward crossing is recorded.

// File: rtl/sedu_pkg.sv
package sedu_pkg;
  typedef enum logic [1:0] {
    PM_RUN     = 2'd0,
    PM_STOP0   = 2'd1,
    PM_STOP1   = 2'd2,
    PM_STANDBY = 2'd3
  } pmode_e;

  typedef struct packed {
    logic evt_en;
    logic irq_en;
    logic fall_en;
    logic rise_en;
  } mode_t;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_MODE   = 2'd1;
  localparam logic [1:0] A_STATUS = 2'd2;

  localparam int N_EDGE = 2;
  localparam int E_RISE = 0;
  localparam int E_FALL = 1;
endpackage

// File: rtl/sedu_sync.sv
module sedu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sedu_edge.sv
module sedu_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic active,
  output logic rise,
  output logic fall
);
  logic prev_q;

  // The previous level is tracked even while inactive, so re-enabling
  // detection with a high level gives no false crossing.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = active &  level & ~prev_q;
  assign fall = active & ~level &  prev_q;
endmodule

// File: rtl/sedu_pend.sv
module sedu_pend (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/supply_edge_unit.sv
module supply_edge_unit
  import sedu_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LVL_W       = 3,
  parameter int DW          = 8,
  parameter int AW          = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             cmp_in,
  input  logic [1:0]       lp_mode,
  output logic [LVL_W-1:0] lvl_sel,
  output logic             det_on,
  output logic             irq,
  output logic             evt
);
  localparam int MODE_W = $bits(mode_t);
  localparam int CTRL_W = LVL_W + 1;

  logic             ctrl_en;
  logic [LVL_W-1:0] ctrl_lvl;
  mode_t            mode_q;
  logic             above_q;
  logic             irq_q;
  logic             evt_q;
  logic             det_q;
  logic [DW-1:0]    rdata_q;

  logic             cmp_sync;
  logic             active;
  logic             edge_rise;
  logic             edge_fall;
  logic [N_EDGE-1:0] hit;
  logic [N_EDGE-1:0] clr;
  logic [N_EDGE-1:0] pend;

  logic wr_ctrl, wr_mode, wr_status;

  assign wr_ctrl   = reg_wr && (reg_addr == AW'(A_CTRL));
  assign wr_mode   = reg_wr && (reg_addr == AW'(A_MODE));
  assign wr_status = reg_wr && (reg_addr == AW'(A_STATUS));

  assign active = ctrl_en && (pmode_e'(lp_mode) != PM_STANDBY);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= 1'b0;
      ctrl_lvl <= '0;
    end else if (wr_ctrl) begin
      ctrl_en  <= reg_wdata[0];
      ctrl_lvl <= reg_wdata[LVL_W:1];
    end
  end

  // A mode write replaces all four enables at once.
  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (wr_mode) mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
  end

  sedu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_in),
    .q   (cmp_sync)
  );

  sedu_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .level  (cmp_sync),
    .active (active),
    .rise   (edge_rise),
    .fall   (edge_fall)
  );

  assign hit[E_RISE] = edge_rise & mode_q.rise_en;
  assign hit[E_FALL] = edge_fall & mode_q.fall_en;

  generate
    for (genvar e = 0; e < N_EDGE; e++) begin : g_pend
      assign clr[e] = wr_status & reg_wdata[e+1];
      sedu_pend u_pend (
        .clk (clk),
        .rst (rst),
        .set (hit[e]),
        .clr (clr[e]),
        .q   (pend[e])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      above_q <= 1'b0;
      irq_q   <= 1'b0;
      evt_q   <= 1'b0;
      det_q   <= 1'b0;
    end else begin
      above_q <= active & cmp_sync;
      irq_q   <= mode_q.irq_en & (|pend);
      evt_q   <= mode_q.evt_en & (|hit);
      det_q   <= active;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      case (reg_addr)
        AW'(A_CTRL):   rdata_q[CTRL_W-1:0] <= {ctrl_lvl, ctrl_en};
        AW'(A_MODE):   rdata_q[MODE_W-1:0] <= mode_q;
        AW'(A_STATUS): rdata_q[N_EDGE:0]   <= {pend, above_q};
        default:       rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign lvl_sel   = ctrl_lvl;
  assign det_on    = det_q;
  assign irq       = irq_q;
  assign evt       = evt_q;
endmodule

// File: rtl/supply_edge_unit_chk.sv
module supply_edge_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [1:0] lp_mode,
  input logic [3:0] mode_bits,
  input logic [1:0] hit,
  input logic [1:0] clr,
  input logic [1:0] pend,
  input logic       det_on,
  input logic       irq,
  input logic       evt
);
  // R10
  standby_off_chk: assert property (@(posedge clk) disable iff (rst)
    (lp_mode == 2'd3) |=> !det_on);

  // R9
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(pend != 2'b00));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    hit[0] |=> pend[0]);

  // R6
  clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    (clr[1] && !hit[1]) |=> !pend[1]);

  // R8
  evt_from_hit_chk: assert property (@(posedge clk) disable iff (rst)
    evt |-> $past(hit != 2'b00));

  // R3
  mode_replace_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd1) |=> (mode_bits == $past(reg_wdata[3:0])));
endmodule

bind supply_edge_unit supply_edge_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .lp_mode   (lp_mode),
  .mode_bits (mode_q),
  .hit       (hit),
  .clr       (clr),
  .pend      (pend),
  .det_on    (det_on),
  .irq       (irq),
  .evt       (evt)
);

// File: tb/supply_edge_unit_tb.sv
`timescale 1ns/1ps
module supply_edge_unit_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       cmp_in;
  logic [1:0] lp_mode;
  logic [2:0] lvl_sel;
  logic       det_on, irq, evt;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  supply_edge_unit u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_in(cmp_in),
    .lp_mode(lp_mode), .lvl_sel(lvl_sel), .det_on(det_on),
    .irq(irq), .evt(evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_cmp(input logic v);
    @(negedge clk);
    cmp_in = v;
    cyc(5);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
    rd(2'd1, d); chk("R1 mode", d, 8'h00);
    rd(2'd2, d); chk("R1 status", d, 8'h00);
    chk("R1 outputs", {irq, evt, det_on}, 3'b000);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr(2'd0, 8'h0F);
    rd(2'd0, d); chk("R2 ctrl readback ext code", d, 8'h0F);
    chk("R2 lvl_sel ext", lvl_sel, 3'd7);
    wr(2'd0, 8'h0B);
    rd(2'd0, d); chk("R2 ctrl readback", d, 8'h0B);
    chk("R2 lvl_sel", lvl_sel, 3'd5);
    rd(2'd3, d); chk("R4 unused address", d, 8'h00);
    chk("R11 det_on active", det_on, 1'b1);
  endtask

  task automatic t_mode();
    logic [7:0] d;
    wr(2'd1, 8'h0F);
    rd(2'd1, d); chk("R3 mode all", d, 8'h0F);
    wr(2'd1, 8'h03);
    rd(2'd1, d); chk("R3 mode replaced", d, 8'h03);
    wr(2'd1, 8'h01);
  endtask

  task automatic t_rise();
    logic [7:0] d;
    int pulses = 0;
    @(negedge clk); cmp_in = 1'b1;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (evt) pulses++; end
    chk("R8 no evt when disabled", pulses, 0);
    rd(2'd2, d); chk("R4 R5 rise pending and level", d, 8'h03);
    chk("R9 no irq when disabled", irq, 1'b0);
  endtask

  task automatic t_fall_unarmed();
    logic [7:0] d;
    set_cmp(1'b0);
    rd(2'd2, d); chk("R5 unarmed fall ignored", d, 8'h02);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(2'd2, 8'h02);
    rd(2'd2, d); chk("R6 clear rise", d, 8'h00);
    wr(2'd1, 8'h03);
    set_cmp(1'b1);
    set_cmp(1'b0);
    rd(2'd2, d); chk("R5 both pending", d, 8'h06);
    wr(2'd2, 8'h04);
    rd(2'd2, d); chk("R6 clear fall only", d, 8'h02);
    wr(2'd2, 8'h00);
    rd(2'd2, d); chk("R6 zero write keeps", d, 8'h02);
  endtask

  task automatic t_race();
    logic [7:0] d;
    wr(2'd1, 8'h01);
    @(negedge clk); cmp_in = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h02;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
    rd(2'd2, d); chk("R7 set wins over clear", d, 8'h03);
    wr(2'd2, 8'h02);
    rd(2'd2, d); chk("R6 clear after race", d, 8'h01);
  endtask

  task automatic t_evt();
    logic [7:0] d;
    int pulses = 0;
    wr(2'd1, 8'h0B);
    @(negedge clk); cmp_in = 1'b0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (evt) pulses++; end
    chk("R8 single evt pulse", pulses, 1);
    chk("R9 irq off while routed off", irq, 1'b0);
    rd(2'd2, d); chk("R5 fall pending", d, 8'h04);
  endtask

  task automatic t_irq();
    wr(2'd2, 8'h06);
    wr(2'd1, 8'h07);
    cyc(2);
    chk("R9 irq low no pending", irq, 1'b0);
    set_cmp(1'b1);
    chk("R9 irq high", irq, 1'b1);
    wr(2'd2, 8'h02);
    cyc(3);
    chk("R9 irq low after clear", irq, 1'b0);
  endtask

  task automatic t_lp();
    logic [7:0] d;
    wr(2'd1, 8'h03);
    @(negedge clk); lp_mode = 2'd1;
    set_cmp(1'b0);
    rd(2'd2, d); chk("R10 stop0 detects", d, 8'h04);
    wr(2'd2, 8'h06);
    @(negedge clk); lp_mode = 2'd2;
    set_cmp(1'b1);
    rd(2'd2, d); chk("R10 stop1 detects", d, 8'h03);
    wr(2'd2, 8'h06);
    set_cmp(1'b0);
    wr(2'd2, 8'h06);
    @(negedge clk); lp_mode = 2'd3;
    cyc(2);
    chk("R11 det_on off in standby", det_on, 1'b0);
    set_cmp(1'b1);
    rd(2'd2, d); chk("R10 standby no detect", d, 8'h00);
    @(negedge clk); lp_mode = 2'd0;
    cyc(4);
    rd(2'd2, d); chk("R10 no crossing on return", d, 8'h01);
    chk("R11 det_on back", det_on, 1'b1);
  endtask

  initial begin
    rst = 1'b1; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    cmp_in = 1'b0; lp_mode = 2'd0;
    cyc(4);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_ctrl();
    t_mode();
    t_rise();
    t_fall_unarmed();
    t_clear();
    t_race();
    t_evt();
    t_irq();
    t_lp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule